// File: doc/BRIEF.md
# HDLC Receive Maximum Length Enforcer

This block sits in a receive HDLC path after flag hunting and bit de-stuffing. It takes a stream of octets framed by a frame-start strobe and a frame-end strobe. Every octet between the two flags is counted: address, control, information and FCS. The count is compared with one limit that is shared by all channels. The limit resets to 0, and the check runs only while a separate enable input is 1.

When a frame grows past the limit, the frame is aborted on that octet. The block emits a one-cycle end-of-frame strobe with the abort bit set. It then drops every later octet of the frame, and the frame's own end strobe, in silence. Frames that stay within the limit pass through octet by octet with one cycle of latency. Their end-of-frame strobe carries the clean status and the octet count. The count saturates, so a very long frame cannot wrap around to a small value.

Input strobes are expected on separate cycles. If they coincide, frame-start wins over frame-end, and frame-end wins over an octet.

Top module: `hdlc_rx_maxlen`

## Requirements
- R1: After synchronous reset, all outputs are 0.
- R2: Each output is registered, with one cycle of latency. A frame-start input gives `out_sof` on the next cycle. Each accepted octet gives `out_vld` with the same `out_data` on the next cycle. At most one of `out_sof`, `out_vld` and `out_eof` is high in any cycle.
- R3: With checking enabled, a frame of exactly `cfg_max_len` octets is accepted. Its frame-end gives `out_eof`=1, `out_abort`=0 and `out_len` equal to the octet count.
- R4: With checking enabled, the octet that makes the count `cfg_max_len`+1 is not emitted. On the next cycle the block gives `out_eof`=1, `out_abort`=1 and `out_len`=`cfg_max_len`+1, or the saturated maximum if that sum would not fit.
- R5: After an abort, the remaining octets of that frame and its frame-end strobe produce no output.
- R6: With `cfg_len_en`=0, no frame is aborted, whatever its length.
- R7: The octet counter saturates at 2^LEN_W-1. A longer frame reports that value in `out_len`.
- R8: A frame-start clears the count, so the frame that follows an aborted frame is processed normally.
- R9: Octets and frame-end strobes that arrive outside a frame produce no output.
- R10: With checking enabled and `cfg_max_len`=0, the first octet of a frame aborts it, and `out_len` reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_en | input | 1 | Enables the length check |
| cfg_max_len | input | LEN_W | Largest accepted frame length, in octets |
| in_sof | input | 1 | Frame-start strobe (opening flag seen) |
| in_eof | input | 1 | Frame-end strobe (closing flag seen) |
| in_vld | input | 1 | Octet-valid strobe |
| in_data | input | 8 | Received octet |
| out_sof | output | 1 | Frame-start, delayed |
| out_vld | output | 1 | Accepted octet valid |
| out_data | output | 8 | Accepted octet |
| out_eof | output | 1 | End-of-frame status strobe |
| out_abort | output | 1 | With `out_eof`: the frame exceeded the limit |
| out_len | output | LEN_W | With `out_eof`: the frame's octet count (saturating) |

## Verification
The bench builds the block with LEN_W=4, so the counter saturates at 15. This puts saturation within reach with frames of about twenty octets. It also makes possible a limit equal to the counter maximum, where the abort length and the saturation point coincide. A limit of 0 and empty frames are reached with the same width. The frames run back to back, so every aborted frame is followed at once by a frame that must pass cleanly.

// File: rtl/hdlc_maxlen_pkg.sv
package hdlc_maxlen_pkg;

    localparam int OCTET_W = 8;

    typedef logic [OCTET_W-1:0] octet_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } frm_state_t;

    typedef struct packed {
        logic   sof;
        logic   vld;
        logic   eof;
        logic   abort;
        octet_t data;
    } beat_t;

    localparam beat_t BEAT_NONE = '{sof: 1'b0, vld: 1'b0, eof: 1'b0, abort: 1'b0, data: '0};

endpackage

// File: rtl/hdlc_len_counter.sv
module hdlc_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] cnt_next
);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    // Saturating successor: a full counter keeps its value.
    assign cnt_next = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt_next;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> ((cnt == CNT_MAX) || $past(clr))) else $error("counter wrapped"); // R7

endmodule

// File: rtl/hdlc_len_ctrl.sv
module hdlc_len_ctrl
    import hdlc_maxlen_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  len_en,
    input  logic [LEN_W-1:0]      max_len,
    input  logic                  sof,
    input  logic                  eof,
    input  logic                  vld,
    input  octet_t                data,
    input  logic [LEN_W-1:0]      cnt,
    input  logic [LEN_W-1:0]      cnt_next,
    output logic                  cnt_clr,
    output logic                  cnt_inc,
    output beat_t                 beat,
    output logic [LEN_W-1:0]      len_rep
);
    frm_state_t state, state_nx;
    logic       over;

    // This octet would bring the count to limit+1 or beyond.
    assign over = len_en && (cnt >= max_len);

    always_comb begin
        state_nx = state;
        beat     = BEAT_NONE;
        len_rep  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        if (sof) begin
            cnt_clr  = 1'b1;
            beat.sof = 1'b1;
            state_nx = ST_PASS;
        end else if (eof) begin
            if (state == ST_PASS) begin
                beat.eof = 1'b1;
                len_rep  = cnt;
            end
            state_nx = ST_IDLE;
        end else if (vld && state != ST_IDLE) begin
            cnt_inc = 1'b1;
            if (state == ST_PASS) begin
                if (over) begin
                    beat.eof   = 1'b1;
                    beat.abort = 1'b1;
                    len_rep    = cnt_next;
                    state_nx   = ST_DROP;
                end else begin
                    beat.vld  = 1'b1;
                    beat.data = data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    AST_SILENT_WHILE_DROPPING: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP && !sof) |-> (beat == BEAT_NONE)) else $error("output while dropping"); // R5

endmodule

// File: rtl/hdlc_rx_maxlen.sv
module hdlc_rx_maxlen
    import hdlc_maxlen_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_len_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_vld,
    input  logic [7:0]       in_data,
    output logic             out_sof,
    output logic             out_vld,
    output logic [7:0]       out_data,
    output logic             out_eof,
    output logic             out_abort,
    output logic [LEN_W-1:0] out_len
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt, cnt_next, len_rep;
    logic             cnt_clr, cnt_inc;
    beat_t            beat, beat_q;

    hdlc_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    hdlc_len_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .len_en   (cfg_len_en),
        .max_len  (cfg_max_len),
        .sof      (in_sof),
        .eof      (in_eof),
        .vld      (in_vld),
        .data     (in_data),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .beat     (beat),
        .len_rep  (len_rep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= BEAT_NONE;
            out_len <= '0;
        end else begin
            beat_q  <= beat;
            out_len <= len_rep;
        end
    end

    assign out_sof   = beat_q.sof;
    assign out_vld   = beat_q.vld;
    assign out_data  = beat_q.data;
    assign out_eof   = beat_q.eof;
    assign out_abort = beat_q.abort;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_sof, out_vld, out_eof})) else $error("strobes overlap"); // R2
    AST_ABORT_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> out_eof) else $error("abort without eof"); // R4
    AST_ABORT_LEN_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> ((out_len > $past(cfg_max_len)) || (out_len == LEN_MAX))) else $error("abort len"); // R4
    AST_ABORT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> $past(cfg_len_en)) else $error("abort while disabled"); // R6

endmodule

// File: tb/hdlc_rx_maxlen_tb.sv
module hdlc_rx_maxlen_tb;
    localparam int LEN_W = 4;
    localparam int NV    = 9;

    // Table columns: limit, enable, frame octets, expected abort, expected out_len, requirement
    localparam int    V_LIM [NV] = '{5, 5, 5, 5, 0, 3, 15, 15, 2};
    localparam bit    V_EN  [NV] = '{1, 1, 1, 0, 1, 1, 0, 1, 1};
    localparam int    V_N   [NV] = '{5, 6, 9, 9, 3, 0, 20, 20, 2};
    localparam bit    V_AB  [NV] = '{0, 1, 1, 0, 1, 0, 0, 1, 0};
    localparam int    V_LEN [NV] = '{5, 6, 6, 9, 1, 0, 15, 15, 2};
    localparam string V_REQ [NV] = '{"R3", "R4", "R5", "R6", "R10", "R3", "R7", "R7", "R8"};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_len_en = 1'b0;
    logic [LEN_W-1:0] cfg_max_len = '0;
    logic             in_sof = 1'b0, in_eof = 1'b0, in_vld = 1'b0;
    logic [7:0]       in_data = '0;
    logic             out_sof, out_vld, out_eof, out_abort;
    logic [7:0]       out_data;
    logic [LEN_W-1:0] out_len;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hdlc_rx_maxlen #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_len_en(cfg_len_en), .cfg_max_len(cfg_max_len),
        .in_sof(in_sof), .in_eof(in_eof), .in_vld(in_vld), .in_data(in_data),
        .out_sof(out_sof), .out_vld(out_vld), .out_data(out_data),
        .out_eof(out_eof), .out_abort(out_abort), .out_len(out_len)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit quiet();
        return !out_sof && !out_vld && !out_eof && !out_abort;
    endfunction

    function automatic int obits();
        return {out_sof, out_vld, out_eof, out_abort};
    endfunction

    task automatic run_frame(input int lim, input bit en, input int n, input bit xab,
                             input int xlen, input string req);
        bit seen_abort = 1'b0;
        @(negedge clk);
        cfg_max_len = lim[LEN_W-1:0];
        cfg_len_en  = en;
        in_sof      = 1'b1;
        @(posedge clk); #1;
        chk(out_sof && !out_vld && !out_eof, "R2", "sof echo", obits(), 8);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_sof  = 1'b0;
            in_vld  = 1'b1;
            in_data = 8'hA0 + i[7:0];
            @(posedge clk); #1;
            if (seen_abort) begin
                chk(quiet(), "R5", "octet after abort", obits(), 0);
            end else if (en && i >= lim) begin
                chk(out_eof && out_abort, req, "abort strobe", obits(), 3);
                chk(out_len == xlen[LEN_W-1:0], "R4", "abort len", out_len, xlen);
                seen_abort = 1'b1;
            end else begin
                chk(out_vld && !out_eof && out_data == 8'hA0 + i[7:0], "R2", "octet pass",
                    out_data, 8'hA0 + i);
            end
        end
        @(negedge clk);
        in_sof = 1'b0;
        in_vld = 1'b0;
        in_eof = 1'b1;
        @(posedge clk); #1;
        if (seen_abort) begin
            chk(quiet(), "R5", "eof after abort", obits(), 0);
        end else begin
            chk(out_eof && !out_abort, req, "clean eof", obits(), 2);
            chk(out_len == xlen[LEN_W-1:0], req, "frame len", out_len, xlen);
        end
        chk(seen_abort == xab, req, "abort seen", seen_abort, xab);
        @(negedge clk);
        in_eof = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(quiet() && out_len == 0 && out_data == 0, "R1", "reset outputs", obits(), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_frame(V_LIM[v], V_EN[v], V_N[v], V_AB[v], V_LEN[v], V_REQ[v]);
        end

        // R8: a frame straight after an aborted one starts from zero
        run_frame(2, 1'b1, 4, 1'b1, 3, "R8");
        run_frame(4, 1'b1, 4, 1'b0, 4, "R8");

        // R9: octets and frame-end outside a frame are ignored
        @(negedge clk);
        in_vld  = 1'b1;
        in_data = 8'h55;
        @(posedge clk); #1;
        chk(quiet(), "R9", "stray octet", obits(), 0);
        @(negedge clk);
        in_vld = 1'b0;
        in_eof = 1'b1;
        @(posedge clk); #1;
        chk(quiet(), "R9", "stray eof", obits(), 0);
        @(negedge clk);
        in_eof = 1'b0;

        // R10 again under a back-to-back pattern, then recovery with the check off (R6)
        run_frame(0, 1'b1, 1, 1'b1, 1, "R10");
        run_frame(0, 1'b0, 3, 1'b0, 3, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule